// File: doc/BRIEF.md
# Configurable Interrupt Input Capture

This block watches a set of interrupt request lines and turns each into a sticky pending flag. Every line has its own build-time settings: whether it is sensed by edge or by level, which polarity counts as active, and whether it passes through a two-flop synchronizer because it comes from another clock domain. A line that is tied to the local clock is sampled directly.

Once a condition is recorded, the flag stays set until a one-cycle clear pulse arrives for that line. Recording does not depend on any enable. The block does no prioritisation, masking or request generation. A downstream controller reads the flag vector and uses the per-line strobe, which marks the cycle in which a flag is newly set.

All pins are plain control and status signals. There is no streamed data, so there is no valid/ready handshake. The clear input is a level that is sampled on every clock edge, and the status outputs cannot be stalled.

Top module: `irq_capture`

## Requirements
- R1: A level-sensed line sets its status bit at the clock edge where its sample is at the active level. The active level is high when its ACT_LOW bit is 0 and low when that bit is 1.
- R2: An edge-sensed line sets its status bit only when an inactive sample is followed by an active sample. A line that stays active sets nothing further.
- R3: Polarity is chosen per line. With ACT_LOW bit 1, an edge-sensed line captures on a falling edge and a level-sensed line captures on a low level.
- R4: A set status bit stays set until irq_clr for that line is sampled high. This holds even after a level-sensed line returns to inactive.
- R5: While a status bit is set, further active edges or levels on that line change neither irq_status nor irq_new.
- R6: A clear wins over a capture in the same cycle. An edge seen in the clear cycle is lost, and the bit reads 0 after that edge.
- R7: A level-sensed line that is still active in the cycle after its clear is captured again at the next edge.
- R8: irq_new pulses high for exactly one cycle, in the cycle where the matching status bit goes from 0 to 1, and at no other time.
- R9: A directly sampled line is reflected one clock edge after it is driven. A line with its ASYNC_SEL bit set is reflected two edges later than that.
- R10: While reset is low and after it is released, all status and strobe bits read 0. An edge-sensed line held at its active level through reset is not captured until it has gone inactive and then active again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_IRQ | Raw interrupt request lines |
| irq_clr | input | N_IRQ | Per-line clear pulse (acknowledge) |
| irq_status | output | N_IRQ | Sticky pending flags |
| irq_new | output | N_IRQ | One-cycle strobe when a flag is newly set |

## Verification
A corrupted edge history shows up at the ports within one cycle, as a spurious or missing capture and an irq_new pulse out of step with irq_status. A wrong synchronizer reset value or stage count moves or creates captures within two cycles after reset, or after an input change. A faulty hold path lets a flag drop without a clear. A faulty clear path lets a flag survive one. Either is visible at the next edge, and the bench compares every line against its model on every cycle.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;

  typedef enum logic {
    SENSE_LEVEL = 1'b0,
    SENSE_EDGE  = 1'b1
  } sense_e;

  // Reset value of the raw synchronizer chain. Edge lanes start at the active
  // raw level so that a line held active through reset shows no edge.
  // Level lanes start at the inactive raw level so they record nothing.
  function automatic logic sync_rst_val(input logic is_edge, input logic act_low);
    return is_edge ? ~act_low : act_low;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_lane.sv
module irq_lane
  import irq_cap_pkg::*;
#(
  parameter sense_e SENSE       = SENSE_LEVEL,
  parameter logic   ACT_LOW     = 1'b0,
  parameter logic   ASYNC       = 1'b0,
  parameter int     SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic clr,
  output logic status,
  output logic fresh
);
  localparam logic IS_EDGE = (SENSE == SENSE_EDGE);
  localparam logic SYNC_RV = sync_rst_val(IS_EDGE, ACT_LOW);

  logic samp;
  logic act;
  logic hit;

  // input sampling: synchronized or direct
  generate
    if (ASYNC) begin : g_sync
      irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RV)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(samp)
      );
    end else begin : g_direct
      assign samp = raw;
    end
  endgenerate

  // normalize so that 1 always means active
  assign act = samp ^ ACT_LOW;

  // detection
  generate
    if (IS_EDGE) begin : g_edge
      logic hist;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist <= 1'b1;
        else        hist <= act;
      end
      assign hit = act & ~hist;
    end else begin : g_level
      assign hit = act;
    end
  endgenerate

  // sticky hold with clear precedence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= 1'b0;
      fresh  <= 1'b0;
    end else begin
      status <= clr ? 1'b0 : (status | hit);
      fresh  <= ~clr & ~status & hit;
    end
  end
endmodule

// File: rtl/irq_capture.sv
module irq_capture
  import irq_cap_pkg::*;
#(
  parameter int               N_IRQ       = 8,
  parameter logic [N_IRQ-1:0] EDGE_SEL    = 8'hF0,
  parameter logic [N_IRQ-1:0] ACT_LOW     = 8'hCC,
  parameter logic [N_IRQ-1:0] ASYNC_SEL   = 8'hAA,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic [N_IRQ-1:0] irq_clr,
  output logic [N_IRQ-1:0] irq_status,
  output logic [N_IRQ-1:0] irq_new
);
  generate
    for (genvar i = 0; i < N_IRQ; i++) begin : g_lane
      localparam sense_e LSENSE = EDGE_SEL[i] ? SENSE_EDGE : SENSE_LEVEL;
      irq_lane #(
        .SENSE      (LSENSE),
        .ACT_LOW    (ACT_LOW[i]),
        .ASYNC      (ASYNC_SEL[i]),
        .SYNC_STAGES(SYNC_STAGES)
      ) u_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (irq_in[i]),
        .clr   (irq_clr[i]),
        .status(irq_status[i]),
        .fresh (irq_new[i])
      );
    end
  endgenerate
endmodule

// File: rtl/irq_capture_chk.sv
module irq_capture_chk #(
  parameter int N_IRQ = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_IRQ-1:0] irq_clr,
  input logic [N_IRQ-1:0] irq_status,
  input logic [N_IRQ-1:0] irq_new
);
  // R4
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(irq_status) & ~$past(irq_clr) & ~irq_status) == '0));

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_status & $past(irq_clr)) == '0));

  // R8
  strobe_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_status & ~$past(irq_status)) == irq_new));

  // R5
  no_strobe_when_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_new & $past(irq_status)) == '0));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (irq_status == '0 && irq_new == '0));
endmodule

bind irq_capture irq_capture_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_clr(irq_clr),
  .irq_status(irq_status), .irq_new(irq_new)
);

// File: tb/irq_capture_bench.sv
`timescale 1ns/100ps
module irq_capture_bench;
  localparam int N = 8;
  localparam logic [N-1:0] EDGE  = 8'hF0;
  localparam logic [N-1:0] ALOW  = 8'hCC;
  localparam logic [N-1:0] ASYN  = 8'hAA;
  localparam logic [N-1:0] IDLE  = ALOW;
  localparam logic [N-1:0] SRST  = EDGE ^ ALOW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_in = IDLE;
  logic [N-1:0] irq_clr = '0;
  logic [N-1:0] irq_status, irq_new;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_capture #(.N_IRQ(N), .EDGE_SEL(EDGE), .ACT_LOW(ALOW), .ASYNC_SEL(ASYN)) u_irq_capture (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_clr(irq_clr),
    .irq_status(irq_status), .irq_new(irq_new)
  );

  // reference model built from the requirements
  logic [N-1:0] m_s1, m_s2, m_hist, m_status, m_new;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= SRST; m_s2 <= SRST; m_hist <= EDGE;
      m_status <= '0; m_new <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        logic s, a, h;
        s = ASYN[i] ? m_s2[i] : irq_in[i];
        a = s ^ ALOW[i];
        h = EDGE[i] ? (a & ~m_hist[i]) : a;
        m_hist[i]   <= a;
        m_status[i] <= irq_clr[i] ? 1'b0 : (m_status[i] | h);
        m_new[i]    <= ~irq_clr[i] & ~m_status[i] & h;
      end
      m_s1 <= irq_in;
      m_s2 <= m_s1;
    end
  end

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle model comparison: level lanes R1, edge lanes R2, strobes R8
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      check("R1", irq_status & ~EDGE, m_status & ~EDGE);
      check("R2", irq_status & EDGE, m_status & EDGE);
      check("R8", irq_new, m_new);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    // R10: lane4 (rising) and lane6 (falling) held active through reset
    irq_in = IDLE;
    irq_in[4] = 1'b1;
    irq_in[6] = 1'b0;
    cyc(3);
    check("R10", irq_status, '0);
    check("R10", irq_new, '0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    cyc(4);
    check("R10", irq_status, '0);
    irq_in = IDLE;
    cyc(2);
    check("R10", irq_status, '0);

    // R2 / R8: one inactive sample then one active sample on lane4
    irq_in[4] = 1'b1;
    cyc(1);
    check("R2", {7'b0, irq_status[4]}, 8'd1);
    check("R8", {7'b0, irq_new[4]}, 8'd1);
    cyc(1);
    check("R8", {7'b0, irq_new[4]}, 8'd0);
    // R5: a further edge on a held lane has no effect
    irq_in[4] = 1'b0; cyc(1);
    irq_in[4] = 1'b1; cyc(1);
    check("R5", {7'b0, irq_new[4]}, 8'd0);
    check("R5", {7'b0, irq_status[4]}, 8'd1);
    // R6: clear together with a new edge loses the edge
    irq_in[4] = 1'b0; cyc(1);
    irq_in[4] = 1'b1; irq_clr[4] = 1'b1; cyc(1);
    irq_clr[4] = 1'b0;
    check("R6", {7'b0, irq_status[4]}, 8'd0);
    cyc(2);
    check("R6", {7'b0, irq_status[4]}, 8'd0);
    irq_in = IDLE; cyc(1);

    // R3: falling edge on lane6
    irq_in[6] = 1'b0; cyc(1);
    check("R3", {7'b0, irq_status[6]}, 8'd1);
    // R3 / R4: active-low level on lane2, short pulse, held afterwards
    irq_in[2] = 1'b0; cyc(1);
    irq_in[2] = 1'b1;
    check("R3", {7'b0, irq_status[2]}, 8'd1);
    cyc(3);
    check("R4", {7'b0, irq_status[2]}, 8'd1);

    // R7: level lane0 held active across a clear
    irq_in[0] = 1'b1; cyc(1);
    irq_clr[0] = 1'b1; cyc(1);
    irq_clr[0] = 1'b0;
    check("R7", {7'b0, irq_status[0]}, 8'd0);
    cyc(1);
    check("R7", {7'b0, irq_status[0]}, 8'd1);
    irq_in[0] = 1'b0;

    // R9: synchronized lane1 lags two edges
    irq_in[1] = 1'b1; cyc(1);
    check("R9", {7'b0, irq_status[1]}, 8'd0);
    cyc(1);
    check("R9", {7'b0, irq_status[1]}, 8'd0);
    cyc(1);
    check("R9", {7'b0, irq_status[1]}, 8'd1);
    irq_in = IDLE;
    irq_clr = '1; cyc(1);
    irq_clr = '0; cyc(3);

    // random phase, checked against the model each cycle
    for (int k = 0; k < 4000; k++) begin
      irq_in  = irq_in ^ (N'($urandom) & N'($urandom) & N'($urandom));
      irq_clr = N'($urandom) & N'($urandom) & N'($urandom);
      cyc(1);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule